// File: doc/BRIEF.md
# Fixed-Length 16-bit Instruction Decoder

This block is the purely combinational decode stage of a small load/store processor whose instructions are all 16 bits long. It takes one instruction word and turns it into the control bundle that the rest of the pipeline consumes. The bundle holds the two read register indices and the register to be written. It also carries the extended immediate and the operation code for the arithmetic unit. Further outputs are the write-back source, the memory strobes, the branch and jump indications, and the halt and illegal-instruction flags.

The 5-bit opcode sits in the top bits of the word. Three layouts share the remaining 11 bits. The short-immediate layout has two register fields and a 5-bit constant. The register layout has three register fields and a 2-bit function code. The long-immediate layout has one register field and an 8-bit constant, or an 11-bit displacement with no register field. Each opcode picks its own constant width and chooses between sign and zero extension. The two link-producing jumps always target register 7. The store-with-update instruction both writes memory and writes its address register.

Top module: `rvd_decoder`

## Requirements
- R1: `rs_idx_o` always equals instruction bits [10:8] and `rt_idx_o` always equals bits [7:5], for every opcode.
- R2: Opcodes 01000 (add-imm), 01001 (reverse-subtract-imm), 10000 (store), 10001 (load) and 10011 (store-update) sign-extend bits [4:0]. Opcodes 01010 (xor-imm), 01011 (and-not-imm) and 10100..10111 (shift/rotate-imm) zero-extend bits [4:0]. All of these drive `imm_vld_o`=1.
- R3: Opcodes 011xx (branches), 11000 (load-immediate), 00101 and 00111 (link jumps) sign-extend bits [7:0]. Opcode 10010 (shift-and-load-byte) zero-extends bits [7:0]. Opcode 00100 (plain jump) sign-extends bits [10:0].
- R4: Register-layout opcodes write `rd_idx_o` = bits [4:2], with `reg_we_o`=1 and `wb_sel_o`=0. `alu_op_o` is 1+func for 11011 (1 add, 2 reverse-subtract, 3 xor, 4 and-not). It is 5+func for 11010 (5 rotate-left, 6 shift-left, 7 rotate-right, 8 shift-right). For 111xx it is 9+opcode[1:0] (9 equal, 10 less, 11 less-or-equal, 12 carry-out), and it is 13 for 11001 (bit reverse).
- R5: Short-immediate ALU opcodes write `rd_idx_o` = bits [7:5] with `wb_sel_o`=0. `alu_op_o` is 1,2,3,4 for 01000..01011 and 5,6,7,8 for 10100..10111.
- R6: Load (10001) asserts `mem_rd_o`, `reg_we_o`, `wb_sel_o`=1, `rd_idx_o`=bits [7:5] and `alu_op_o`=1. Store (10000) asserts `mem_wr_o` with `alu_op_o`=1 and no register write. Read and write are never both high.
- R7: Store-update (10011) asserts both `mem_wr_o` and `reg_we_o`, with `rd_idx_o` = bits [10:8], `wb_sel_o`=0 and `alu_op_o`=1.
- R8: 00101 and 00111 assert `jump_o` and `reg_we_o`, with `rd_idx_o`=7 and `wb_sel_o`=2. Only 00111 asserts `jump_reg_o`, and it sets `alu_op_o`=1. 00100 asserts `jump_o` with no write.
- R9: Opcodes 011xx assert `branch_o` with `br_cond_o` = opcode[1:0] (0 zero, 1 non-zero, 2 negative, 3 non-negative) and no writes. At most one of branch, jump, halt and illegal is high.
- R10: 11000 sets `alu_op_o`=14 (pass operand B). 10010 sets `alu_op_o`=15 (shift left 8 and OR). Both write `rd_idx_o` = bits [10:8].
- R11: 00000 asserts `halt_o` with no writes. 00001 leaves every control output low.
- R12: Opcodes 00010, 00011 and 00110 assert `illegal_o` and keep `reg_we_o`, `mem_rd_o` and `mem_wr_o` low.
- R13: Whenever `reg_we_o` is 0, `rd_idx_o`=0 and `wb_sel_o`=0. Whenever `imm_vld_o` is 0, `imm_o`=0. `alu_op_o`=0 and `br_cond_o`=0 where unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word |
| rs_idx_o | output | 3 | First read register index |
| rt_idx_o | output | 3 | Second read register index |
| rd_idx_o | output | 3 | Register written back |
| imm_o | output | 16 | Extended immediate |
| imm_vld_o | output | 1 | Immediate is used by this opcode |
| alu_op_o | output | 4 | Arithmetic unit operation code |
| reg_we_o | output | 1 | Register write enable |
| wb_sel_o | output | 2 | Write-back source: 0 ALU, 1 memory, 2 link |
| mem_rd_o | output | 1 | Memory read enable |
| mem_wr_o | output | 1 | Memory write enable |
| branch_o | output | 1 | Conditional branch |
| br_cond_o | output | 2 | Branch condition code |
| jump_o | output | 1 | Unconditional jump |
| jump_reg_o | output | 1 | Jump target comes from a register |
| halt_o | output | 1 | Halt instruction |
| illegal_o | output | 1 | Unimplemented opcode |

## Verification
The bench targets the constants whose top bit is set. A decoder that mixed up sign and zero extension would give xor-imm or shift-and-load-byte a negative constant, or give add-imm and the 11-bit jump a positive one. It also tries the link jumps with non-zero register fields, where a decoder that took the destination from the word would write the wrong register. Store-update is checked because a decoder that dropped either half would lose the memory write or the address update. The unlisted opcodes are checked because any stray write enable there would corrupt state.

// File: rtl/rvd_pkg.sv
package rvd_pkg;

   typedef enum logic [3:0] {
      ALU_NONE  = 4'd0,  ALU_ADD  = 4'd1,  ALU_RSUB = 4'd2,  ALU_XOR  = 4'd3,
      ALU_ANDN  = 4'd4,  ALU_ROL  = 4'd5,  ALU_SLL  = 4'd6,  ALU_ROR  = 4'd7,
      ALU_SRL   = 4'd8,  ALU_SEQ  = 4'd9,  ALU_SLT  = 4'd10, ALU_SLE  = 4'd11,
      ALU_SCO   = 4'd12, ALU_BTR  = 4'd13, ALU_PASSB = 4'd14, ALU_SLBI = 4'd15
   } alu_op_e;

   typedef enum logic [2:0] {
      IMK_NONE, IMK_S5, IMK_Z5, IMK_S8, IMK_Z8, IMK_S11
   } imm_kind_e;

   typedef enum logic [1:0] {
      WB_ALU = 2'd0, WB_MEM = 2'd1, WB_LINK = 2'd2
   } wb_sel_e;

   typedef enum logic [2:0] {
      DST_NONE, DST_MID, DST_HI, DST_LO, DST_LINK
   } dst_e;

   typedef struct packed {
      imm_kind_e imk;
      dst_e      dst;
      wb_sel_e   wb;
      logic      mrd;
      logic      mwr;
      logic      br;
      logic      jmp;
      logic      jreg;
      logic      halt;
      logic      ill;
   } ctrl_t;

   localparam logic [4:0] OP_HALT  = 5'b00000;
   localparam logic [4:0] OP_NOP   = 5'b00001;
   localparam logic [4:0] OP_TRAP  = 5'b00010;
   localparam logic [4:0] OP_J     = 5'b00100;
   localparam logic [4:0] OP_JAL   = 5'b00101;
   localparam logic [4:0] OP_JALR  = 5'b00111;
   localparam logic [4:0] OP_ADDI  = 5'b01000;
   localparam logic [4:0] OP_SUBI  = 5'b01001;
   localparam logic [4:0] OP_XORI  = 5'b01010;
   localparam logic [4:0] OP_ANDNI = 5'b01011;
   localparam logic [4:0] OP_ST    = 5'b10000;
   localparam logic [4:0] OP_LD    = 5'b10001;
   localparam logic [4:0] OP_SLBI  = 5'b10010;
   localparam logic [4:0] OP_STU   = 5'b10011;
   localparam logic [4:0] OP_LBI   = 5'b11000;
   localparam logic [4:0] OP_BTR   = 5'b11001;
   localparam logic [4:0] OP_SHR   = 5'b11010;
   localparam logic [4:0] OP_ARR   = 5'b11011;

endpackage

// File: rtl/rvd_ctrl.sv
module rvd_ctrl
   import rvd_pkg::*;
#(
   parameter int OPC_W = 5
) (
   input  logic [OPC_W-1:0] opc_i,
   output ctrl_t            ctrl_o
);

   generate
      if (OPC_W != 5) begin : g_bad_opc
         $error("rvd_ctrl: opcode width must be 5");
      end
   endgenerate

   always_comb begin
      ctrl_o     = '0;
      ctrl_o.imk = IMK_NONE;
      ctrl_o.dst = DST_NONE;
      ctrl_o.wb  = WB_ALU;
      unique casez (opc_i)
         OP_HALT: ctrl_o.halt = 1'b1;
         OP_NOP:  ;
         OP_ADDI, OP_SUBI: begin
            ctrl_o.imk = IMK_S5;
            ctrl_o.dst = DST_MID;
         end
         OP_XORI, OP_ANDNI, 5'b101??: begin
            ctrl_o.imk = IMK_Z5;
            ctrl_o.dst = DST_MID;
         end
         OP_ST: begin
            ctrl_o.imk = IMK_S5;
            ctrl_o.mwr = 1'b1;
         end
         OP_LD: begin
            ctrl_o.imk = IMK_S5;
            ctrl_o.dst = DST_MID;
            ctrl_o.wb  = WB_MEM;
            ctrl_o.mrd = 1'b1;
         end
         OP_STU: begin
            ctrl_o.imk = IMK_S5;
            ctrl_o.dst = DST_HI;
            ctrl_o.mwr = 1'b1;
         end
         OP_BTR, OP_SHR, OP_ARR, 5'b111??: ctrl_o.dst = DST_LO;
         5'b011??: begin
            ctrl_o.imk = IMK_S8;
            ctrl_o.br  = 1'b1;
         end
         OP_LBI: begin
            ctrl_o.imk = IMK_S8;
            ctrl_o.dst = DST_HI;
         end
         OP_SLBI: begin
            ctrl_o.imk = IMK_Z8;
            ctrl_o.dst = DST_HI;
         end
         OP_J: begin
            ctrl_o.imk = IMK_S11;
            ctrl_o.jmp = 1'b1;
         end
         OP_JAL, OP_JALR: begin
            ctrl_o.imk  = IMK_S8;
            ctrl_o.dst  = DST_LINK;
            ctrl_o.wb   = WB_LINK;
            ctrl_o.jmp  = 1'b1;
            ctrl_o.jreg = opc_i[1];
         end
         default: ctrl_o.ill = 1'b1;
      endcase
   end

endmodule

// File: rtl/rvd_alu_sel.sv
module rvd_alu_sel
   import rvd_pkg::*;
#(
   parameter int OPC_W  = 5,
   parameter int FUNC_W = 2
) (
   input  logic [OPC_W-1:0]  opc_i,
   input  logic [FUNC_W-1:0] func_i,
   output alu_op_e           op_o
);

   localparam int GROUP = 1 << FUNC_W;

   generate
      if (GROUP != 4) begin : g_bad_func
         $error("rvd_alu_sel: function field must select four operations");
      end
   endgenerate

   logic [3:0] arith_base;
   logic [3:0] shift_base;
   logic [3:0] cmp_base;
   assign arith_base = 4'(ALU_ADD);
   assign shift_base = 4'(ALU_ROL);
   assign cmp_base   = 4'(ALU_SEQ);

   always_comb begin
      op_o = ALU_NONE;
      unique casez (opc_i)
         5'b010??: op_o = alu_op_e'(arith_base + 4'(opc_i[1:0]));
         5'b101??: op_o = alu_op_e'(shift_base + 4'(opc_i[1:0]));
         OP_ARR:   op_o = alu_op_e'(arith_base + 4'(func_i));
         OP_SHR:   op_o = alu_op_e'(shift_base + 4'(func_i));
         5'b111??: op_o = alu_op_e'(cmp_base + 4'(opc_i[1:0]));
         OP_BTR:   op_o = ALU_BTR;
         OP_LBI:   op_o = ALU_PASSB;
         OP_SLBI:  op_o = ALU_SLBI;
         OP_ST, OP_LD, OP_STU, OP_JALR: op_o = ALU_ADD;
         default:  op_o = ALU_NONE;
      endcase
   end

endmodule

// File: rtl/rvd_imm_gen.sv
module rvd_imm_gen
   import rvd_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int FIELD_W = 11
) (
   input  logic [FIELD_W-1:0] field_i,
   input  imm_kind_e          kind_i,
   output logic [DATA_W-1:0]  imm_o
);

   localparam int NUM_W = 3;

   generate
      if (DATA_W <= FIELD_W) begin : g_bad_data
         $error("rvd_imm_gen: data width must exceed the longest immediate field");
      end
   endgenerate

   logic [DATA_W-1:0] sx [NUM_W];
   logic [DATA_W-1:0] zx [NUM_W];

   for (genvar g = 0; g < NUM_W; g++) begin : g_ext
      localparam int FW = (g == 0) ? 5 : (g == 1) ? 8 : FIELD_W;
      assign sx[g] = {{(DATA_W-FW){field_i[FW-1]}}, field_i[FW-1:0]};
      assign zx[g] = {{(DATA_W-FW){1'b0}}, field_i[FW-1:0]};
   end

   always_comb begin
      unique case (kind_i)
         IMK_S5:  imm_o = sx[0];
         IMK_Z5:  imm_o = zx[0];
         IMK_S8:  imm_o = sx[1];
         IMK_Z8:  imm_o = zx[1];
         IMK_S11: imm_o = sx[2];
         default: imm_o = '0;
      endcase
   end

   always_comb begin
      if (kind_i == IMK_S5)
         AST_SHORT_SIGN: assert (imm_o[DATA_W-1] == field_i[4]); // R2
      if (kind_i == IMK_Z5)
         AST_SHORT_ZERO: assert (imm_o[DATA_W-1:5] == '0); // R2
      if (kind_i == IMK_S8)
         AST_BYTE_SIGN: assert (imm_o[DATA_W-1] == field_i[7]); // R3
      if (kind_i == IMK_S11)
         AST_DISP_SIGN: assert (imm_o[DATA_W-1] == field_i[FIELD_W-1]); // R3
   end

endmodule

// File: rtl/rvd_decoder.sv
module rvd_decoder
   import rvd_pkg::*;
#(
   parameter int INSTR_W  = 16,
   parameter int DATA_W   = 16,
   parameter int REG_W    = 3,
   parameter int OPC_W    = 5,
   parameter int FUNC_W   = 2,
   parameter int LINK_REG = 7
) (
   input  logic [INSTR_W-1:0] instr_i,
   output logic [REG_W-1:0]   rs_idx_o,
   output logic [REG_W-1:0]   rt_idx_o,
   output logic [REG_W-1:0]   rd_idx_o,
   output logic [DATA_W-1:0]  imm_o,
   output logic               imm_vld_o,
   output logic [3:0]         alu_op_o,
   output logic               reg_we_o,
   output logic [1:0]         wb_sel_o,
   output logic               mem_rd_o,
   output logic               mem_wr_o,
   output logic               branch_o,
   output logic [1:0]         br_cond_o,
   output logic               jump_o,
   output logic               jump_reg_o,
   output logic               halt_o,
   output logic               illegal_o
);

   localparam int OPC_LSB = INSTR_W - OPC_W;
   localparam int RS_LSB  = OPC_LSB - REG_W;
   localparam int RT_LSB  = RS_LSB - REG_W;
   localparam int RD_LSB  = RT_LSB - REG_W;
   localparam int FIELD_W = OPC_LSB;

   generate
      if (RD_LSB != FUNC_W) begin : g_bad_layout
         $error("rvd_decoder: fields do not fill the instruction word");
      end
      if (LINK_REG >= (1 << REG_W)) begin : g_bad_link
         $error("rvd_decoder: link register outside register file");
      end
   endgenerate

   logic [OPC_W-1:0]  opc;
   logic [FUNC_W-1:0] func;
   ctrl_t             ctrl;
   alu_op_e           alu_op;

   assign opc  = instr_i[INSTR_W-1:OPC_LSB];
   assign func = instr_i[FUNC_W-1:0];

   rvd_ctrl #(.OPC_W(OPC_W)) u_ctrl (
      .opc_i  (opc),
      .ctrl_o (ctrl)
   );

   rvd_alu_sel #(.OPC_W(OPC_W), .FUNC_W(FUNC_W)) u_alu_sel (
      .opc_i  (opc),
      .func_i (func),
      .op_o   (alu_op)
   );

   rvd_imm_gen #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_imm (
      .field_i (instr_i[FIELD_W-1:0]),
      .kind_i  (ctrl.imk),
      .imm_o   (imm_o)
   );

   assign rs_idx_o = instr_i[OPC_LSB-1:RS_LSB];
   assign rt_idx_o = instr_i[RS_LSB-1:RT_LSB];

   always_comb begin
      unique case (ctrl.dst)
         DST_MID:  rd_idx_o = instr_i[RS_LSB-1:RT_LSB];
         DST_HI:   rd_idx_o = instr_i[OPC_LSB-1:RS_LSB];
         DST_LO:   rd_idx_o = instr_i[RT_LSB-1:RD_LSB];
         DST_LINK: rd_idx_o = REG_W'(LINK_REG);
         default:  rd_idx_o = '0;
      endcase
   end

   assign reg_we_o   = (ctrl.dst != DST_NONE);
   assign imm_vld_o  = (ctrl.imk != IMK_NONE);
   assign alu_op_o   = 4'(alu_op);
   assign wb_sel_o   = 2'(ctrl.wb);
   assign mem_rd_o   = ctrl.mrd;
   assign mem_wr_o   = ctrl.mwr;
   assign branch_o   = ctrl.br;
   assign br_cond_o  = ctrl.br ? opc[1:0] : 2'b00;
   assign jump_o     = ctrl.jmp;
   assign jump_reg_o = ctrl.jreg;
   assign halt_o     = ctrl.halt;
   assign illegal_o  = ctrl.ill;

   always_comb begin
      if (illegal_o)
         AST_ILLEGAL_QUIET: assert (!reg_we_o && !mem_rd_o && !mem_wr_o); // R12
      if (wb_sel_o == 2'(WB_LINK))
         AST_LINK_TARGET: assert (reg_we_o && rd_idx_o == REG_W'(LINK_REG)); // R8
      AST_MEM_EXCL: assert (!(mem_rd_o && mem_wr_o)); // R6
      AST_FLOW_ONEHOT: assert ($onehot0({branch_o, jump_o, halt_o, illegal_o})); // R9
      if (!reg_we_o)
         AST_IDLE_DEST: assert (rd_idx_o == '0 && wb_sel_o == 2'(WB_ALU)); // R13
      if (mem_wr_o && reg_we_o)
         AST_UPDATE_BASE: assert (rd_idx_o == rs_idx_o); // R7
   end

endmodule

// File: tb/rvd_decoder_test.sv
`timescale 1ns/1ps
module rvd_decoder_test;

   typedef struct packed {
      logic [2:0]  rs;
      logic [2:0]  rt;
      logic [2:0]  rd;
      logic [15:0] imm;
      logic        iv;
      logic [3:0]  alu;
      logic        we;
      logic [1:0]  wb;
      logic        mrd;
      logic        mwr;
      logic        br;
      logic [1:0]  cond;
      logic        j;
      logic        jr;
      logic        halt;
      logic        ill;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] instr = 16'h0000;
   exp_t        act;
   int          total = 0;
   int          bad = 0;

   always #2.5 clk = ~clk;

   rvd_decoder uut (
      .instr_i    (instr),
      .rs_idx_o   (act.rs),
      .rt_idx_o   (act.rt),
      .rd_idx_o   (act.rd),
      .imm_o      (act.imm),
      .imm_vld_o  (act.iv),
      .alu_op_o   (act.alu),
      .reg_we_o   (act.we),
      .wb_sel_o   (act.wb),
      .mem_rd_o   (act.mrd),
      .mem_wr_o   (act.mwr),
      .branch_o   (act.br),
      .br_cond_o  (act.cond),
      .jump_o     (act.j),
      .jump_reg_o (act.jr),
      .halt_o     (act.halt),
      .illegal_o  (act.ill)
   );

   function automatic exp_t ref_dec(input logic [15:0] w);
      exp_t e;
      logic [4:0]  op;
      logic [15:0] s5, z5, s8, z8, s11;
      e = '0;
      op = w[15:11];
      e.rs = w[10:8];
      e.rt = w[7:5];
      s5  = {{11{w[4]}}, w[4:0]};
      z5  = {11'b0, w[4:0]};
      s8  = {{8{w[7]}}, w[7:0]};
      z8  = {8'b0, w[7:0]};
      s11 = {{5{w[10]}}, w[10:0]};
      casez (op)
         5'b00000: e.halt = 1'b1;
         5'b00001: ;
         5'b01000, 5'b01001: begin
            e.alu = 4'd1 + 4'(op[1:0]); e.imm = s5; e.iv = 1'b1; e.we = 1'b1; e.rd = w[7:5];
         end
         5'b01010, 5'b01011: begin
            e.alu = 4'd1 + 4'(op[1:0]); e.imm = z5; e.iv = 1'b1; e.we = 1'b1; e.rd = w[7:5];
         end
         5'b101??: begin
            e.alu = 4'd5 + 4'(op[1:0]); e.imm = z5; e.iv = 1'b1; e.we = 1'b1; e.rd = w[7:5];
         end
         5'b10000: begin e.alu = 4'd1; e.imm = s5; e.iv = 1'b1; e.mwr = 1'b1; end
         5'b10001: begin
            e.alu = 4'd1; e.imm = s5; e.iv = 1'b1; e.we = 1'b1; e.rd = w[7:5]; e.wb = 2'd1; e.mrd = 1'b1;
         end
         5'b10011: begin
            e.alu = 4'd1; e.imm = s5; e.iv = 1'b1; e.mwr = 1'b1; e.we = 1'b1; e.rd = w[10:8];
         end
         5'b11001: begin e.alu = 4'd13; e.we = 1'b1; e.rd = w[4:2]; end
         5'b11011: begin e.alu = 4'd1 + 4'(w[1:0]); e.we = 1'b1; e.rd = w[4:2]; end
         5'b11010: begin e.alu = 4'd5 + 4'(w[1:0]); e.we = 1'b1; e.rd = w[4:2]; end
         5'b111??: begin e.alu = 4'd9 + 4'(op[1:0]); e.we = 1'b1; e.rd = w[4:2]; end
         5'b011??: begin e.br = 1'b1; e.cond = op[1:0]; e.imm = s8; e.iv = 1'b1; end
         5'b11000: begin e.alu = 4'd14; e.imm = s8; e.iv = 1'b1; e.we = 1'b1; e.rd = w[10:8]; end
         5'b10010: begin e.alu = 4'd15; e.imm = z8; e.iv = 1'b1; e.we = 1'b1; e.rd = w[10:8]; end
         5'b00100: begin e.j = 1'b1; e.imm = s11; e.iv = 1'b1; end
         5'b00101: begin
            e.j = 1'b1; e.imm = s8; e.iv = 1'b1; e.we = 1'b1; e.rd = 3'd7; e.wb = 2'd2;
         end
         5'b00111: begin
            e.j = 1'b1; e.jr = 1'b1; e.alu = 4'd1; e.imm = s8; e.iv = 1'b1;
            e.we = 1'b1; e.rd = 3'd7; e.wb = 2'd2;
         end
         default: e.ill = 1'b1;
      endcase
      return e;
   endfunction

   function automatic string req_of(input logic [4:0] op);
      casez (op)
         5'b00000, 5'b00001:                    return "R11";
         5'b010??, 5'b101??:                    return "R2/R5";
         5'b10000, 5'b10001:                    return "R6/R2";
         5'b10011:                              return "R7";
         5'b11001, 5'b11010, 5'b11011, 5'b111??: return "R4";
         5'b011??:                              return "R9/R3";
         5'b11000, 5'b10010:                    return "R10/R3";
         5'b00100, 5'b00101, 5'b00111:          return "R8/R3";
         default:                               return "R12";
      endcase
   endfunction

   task automatic apply_check(input logic [15:0] w);
      exp_t e;
      @(negedge clk);
      instr = w;
      #1;
      e = ref_dec(w);
      total++;
      if (act !== e) begin
         bad++;
         $display("FAIL %s instr=%h actual=%h expected=%h", req_of(w[15:11]), w, act, e);
      end
      total++;
      if (act.rs !== w[10:8] || act.rt !== w[7:5]) begin // R1
         bad++;
         $display("FAIL R1 instr=%h actual=%h/%h expected=%h/%h", w, act.rs, act.rt, w[10:8], w[7:5]);
      end
      if (!e.we || !e.iv) begin
         total++;
         if ((!e.we && (act.rd !== 3'd0 || act.wb !== 2'd0)) || (!e.iv && act.imm !== 16'h0)) begin // R13
            bad++;
            $display("FAIL R13 instr=%h actual rd=%h wb=%h imm=%h expected rd=0 wb=0 imm=0",
                     w, act.rd, act.wb, act.imm);
         end
      end
   endtask

   initial begin
      #(200000 * 5);
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0193));
      repeat (3) @(posedge clk);
      #1;
      total++; // reset state with halt word on the bus: R11
      if (act.halt !== 1'b1 || act.we !== 1'b0 || act.mwr !== 1'b0) begin
         bad++;
         $display("FAIL R11 reset halt=%b we=%b mwr=%b expected halt=1 we=0 mwr=0",
                  act.halt, act.we, act.mwr);
      end
      rst_n = 1'b1;
      // directed corners
      apply_check(16'h0000);                 // R11 halt
      apply_check(16'h0FFF);                 // R11 nop with noisy bits
      apply_check({5'b01000, 3'd2, 3'd5, 5'b10000}); // R2 negative add-imm
      apply_check({5'b01010, 3'd1, 3'd3, 5'b11111}); // R2 xor-imm zero-ext
      apply_check({5'b10111, 3'd4, 3'd6, 5'b11111}); // R5 shift-imm
      apply_check({5'b10011, 3'd6, 3'd2, 5'b10101}); // R7 store-update
      apply_check({5'b10001, 3'd3, 3'd4, 5'b11000}); // R6 load
      apply_check({5'b11000, 3'd5, 8'h80});          // R10 load-immediate negative
      apply_check({5'b10010, 3'd5, 8'hFF});          // R10 zero-ext byte
      apply_check({5'b00100, 11'h400});              // R3 negative jump
      apply_check({5'b00101, 3'd3, 8'hF0});          // R8 link forced to 7
      apply_check({5'b00111, 3'd1, 8'h7F});          // R8 register jump
      apply_check({5'b01110, 3'd2, 8'h81});          // R9 branch negative
      apply_check({5'b00010, 11'h7FF});              // R12
      apply_check({5'b00011, 11'h123});              // R12
      apply_check({5'b00110, 11'h5A5});              // R12
      for (int f = 0; f < 4; f++) begin
         apply_check({5'b11011, 3'd1, 3'd2, 3'd3, 2'(f)}); // R4 arithmetic group
         apply_check({5'b11010, 3'd7, 3'd0, 3'd5, 2'(f)}); // R4 shift group
      end
      for (int op = 0; op < 32; op++)
         apply_check({5'(op), 11'($urandom)});
      for (int k = 0; k < 3000; k++)
         apply_check(16'($urandom));
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule